// File: doc/BRIEF.md
# Periodic Timer with Compare-Match Pin

This block is a 10-bit up-counter with two compare registers, A and P. Its outputs are one timer pin, the exact complement of that pin, and a match flag for each comparator. A two-bit mode select picks one of four behaviours:

- **Plain counting:** the pin stays idle.
- **Compare-match output:** an A match drives the pin high, drives it low, toggles it, or leaves it alone.
- **PWM:** P sets the period and A sets the duty.
- **Auxiliary counting:** stands in for the capture and one-shot uses, with the pin idle.

The counter counts only while the run input is high and is held at zero while the run input is low. In the two non-periodic modes a clear-select input chooses what restarts the count: an A match, or a P match. When P is zero, the count instead wraps at the top of its range. In compare mode a low-to-high change of the run input loads the programmed initial level into the pin. A polarity input can invert the pin in the two pin-driving modes.

Top module: `ptmr_top`

## Requirements
- R1: After reset, with run low, `pin_o` is 0, `pin_n_o` is 1, and both match flags are 0.
- R2: While `run_en` is low, the counter is zero one cycle later and both match flags stay 0.
- R3: In modes 00 (count) and 01 (compare), with `clr_sel`=1, the count restarts from zero on the edge after it equals `cmp_a`, giving a period of `cmp_a`+1 cycles.
- R4: In modes 00 and 01, with `clr_sel`=0, the count restarts on the edge after it equals a non-zero `cmp_p`. When `cmp_p` is 0, it wraps after 1023 instead.
- R5: In mode 01, one cycle after `run_en` goes from low to high, the pin level equals `lvl_ctl` (0 = low, 1 = high). While `run_en` is low, the level is held.
- R6: In mode 01, an A match while running (and not in the starting cycle) sets the level one cycle later according to `out_act`: 00 keeps it, 01 drives low, 10 drives high, 11 toggles. An action equal to the current level gives no visible change.
- R7: In mode 10, the count runs over `cmp_p` states (0 means 1024) and `clr_sel` is ignored. One cycle after the count is below `cmp_a`, the level equals `lvl_ctl` (the active level). Otherwise, and while stopped, the level is the inverse of `lvl_ctl`.
- R8: In modes 01 and 10, `pol_inv`=1 inverts `pin_o` with no added delay.
- R9: In modes 00 and 11, `pin_o` is 0 whatever `lvl_ctl` and `pol_inv` are. Mode 11 counts like mode 10 and ignores `clr_sel`.
- R10: `pin_n_o` is always the inverse of `pin_o`.
- R11: `match_a_o` is high while running and the count equals `cmp_a`. `match_p_o` is high while running and the count equals `cmp_p` (modes 00 and 01), or while it sits at the last state of the period (modes 10 and 11).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Counter run enable; a rising edge restarts the compare level |
| mode_sel | input | 2 | 00 count, 01 compare, 10 PWM, 11 auxiliary count |
| out_act | input | 2 | Compare action: 00 keep, 01 low, 10 high, 11 toggle |
| lvl_ctl | input | 1 | Initial level (compare) or active level (PWM) |
| pol_inv | input | 1 | 1 inverts the pin in modes 01 and 10 |
| clr_sel | input | 1 | 1 clears on A match, 0 on P match/overflow (modes 00, 01) |
| cmp_a | input | CNT_W | Comparator A value |
| cmp_p | input | CNT_W | Comparator P value |
| pin_o | output | 1 | Timer pin |
| pin_n_o | output | 1 | Complementary timer pin |
| match_a_o | output | 1 | Comparator A match flag |
| match_p_o | output | 1 | Comparator P match / period-end flag |

## Verification
The match flags and the polarity inversion are combinational from the registered count and the inputs, so they are due in the same cycle as the stimulus. The pin level lags by one register: an A match, a run rising edge or a PWM threshold shows up on the pin at the sample after the next rising edge.

The driver applies inputs just after a falling edge and predicts the outputs for that cycle from its own state. It advances that state across the coming rising edge. The monitor compares its queued prediction against the ports before the next rising edge, so every result is taken in the cycle it is due.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int PT_W = 10;

    typedef enum logic [1:0] {
        PM_COUNT = 2'b00,
        PM_CMP   = 2'b01,
        PM_PWM   = 2'b10,
        PM_AUX   = 2'b11
    } pt_mode_e;

    typedef enum logic [1:0] {
        ACT_KEEP   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } pt_act_e;

    typedef struct packed {
        logic lvl;
        logic run;
    } pt_pin_st_t;

endpackage

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
    parameter int CNT_W = ptmr_pkg::PT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             periodic,
    input  logic             clr_on_a,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_p,
    output logic [CNT_W-1:0] cnt_q,
    output logic             hit_a,
    output logic             hit_p,
    output logic             below_a
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    logic [CNT_W-1:0] last_d;
    logic             eq_a, eq_p, at_max, at_last, wrap_d;

    always_comb begin
        eq_a    = (st_q.cnt == cmp_a);
        eq_p    = (st_q.cnt == cmp_p);
        at_max  = (st_q.cnt == CNT_MAX);
        // last state of a P-defined period; zero selects the full range
        last_d  = (cmp_p == '0) ? CNT_MAX : (cmp_p - CNT_ONE);
        at_last = (st_q.cnt == last_d);

        if (periodic) begin
            wrap_d = at_last;
        end else if (clr_on_a) begin
            wrap_d = eq_a;
        end else if (cmp_p == '0) begin
            wrap_d = at_max;
        end else begin
            wrap_d = eq_p;
        end

        st_d = st_q;
        if (!run_en) begin
            st_d.cnt = '0;
        end else if (wrap_d) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q   = st_q.cnt;
    assign hit_a   = run_en & eq_a;
    assign hit_p   = run_en & (periodic ? at_last : eq_p);
    assign below_a = (st_q.cnt < cmp_a);

endmodule

// File: rtl/ptmr_pinlogic.sv
module ptmr_pinlogic
    import ptmr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run_en,
    input  pt_mode_e mode,
    input  pt_act_e  act,
    input  logic     lvl_ctl,
    input  logic     hit_a,
    input  logic     below_a,
    output logic     lvl_q,
    output logic     run_q
);

    pt_pin_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.run = run_en;
        unique case (mode)
            PM_CMP: begin
                if (!run_en) begin
                    st_d.lvl = st_q.lvl;
                end else if (!st_q.run) begin
                    st_d.lvl = lvl_ctl;
                end else if (hit_a) begin
                    unique case (act)
                        ACT_KEEP:   st_d.lvl = st_q.lvl;
                        ACT_LOW:    st_d.lvl = 1'b0;
                        ACT_HIGH:   st_d.lvl = 1'b1;
                        ACT_TOGGLE: st_d.lvl = ~st_q.lvl;
                        default:    st_d.lvl = st_q.lvl;
                    endcase
                end
            end
            PM_PWM: begin
                if (run_en && below_a) begin
                    st_d.lvl = lvl_ctl;
                end else begin
                    st_d.lvl = ~lvl_ctl;
                end
            end
            default: st_d.lvl = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_q = st_q.lvl;
    assign run_q = st_q.run;

endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
    import ptmr_pkg::*;
#(
    parameter int CNT_W = ptmr_pkg::PT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [1:0]       mode_sel,
    input  logic [1:0]       out_act,
    input  logic             lvl_ctl,
    input  logic             pol_inv,
    input  logic             clr_sel,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_p,
    output logic             pin_o,
    output logic             pin_n_o,
    output logic             match_a_o,
    output logic             match_p_o
);

    pt_mode_e         mode;
    pt_act_e          act;
    logic             periodic, drives_pin;
    logic [CNT_W-1:0] cnt_q;
    logic             hit_a, hit_p, below_a;
    logic             lvl_q, run_q;

    assign mode       = pt_mode_e'(mode_sel);
    assign act        = pt_act_e'(out_act);
    assign periodic   = (mode == PM_PWM) || (mode == PM_AUX);
    assign drives_pin = (mode == PM_CMP) || (mode == PM_PWM);

    ptmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .periodic (periodic),
        .clr_on_a (clr_sel),
        .cmp_a    (cmp_a),
        .cmp_p    (cmp_p),
        .cnt_q    (cnt_q),
        .hit_a    (hit_a),
        .hit_p    (hit_p),
        .below_a  (below_a)
    );

    ptmr_pinlogic u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .mode    (mode),
        .act     (act),
        .lvl_ctl (lvl_ctl),
        .hit_a   (hit_a),
        .below_a (below_a),
        .lvl_q   (lvl_q),
        .run_q   (run_q)
    );

    assign pin_o     = drives_pin ? (lvl_q ^ pol_inv) : 1'b0;
    assign pin_n_o   = ~pin_o;
    assign match_a_o = hit_a;
    assign match_p_o = hit_p;

endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic [1:0]       mode_sel,
    input logic [1:0]       out_act,
    input logic             lvl_ctl,
    input logic             clr_sel,
    input logic [CNT_W-1:0] cmp_a,
    input logic [CNT_W-1:0] cmp_p,
    input logic             match_a_o,
    input logic             match_p_o,
    input logic [CNT_W-1:0] cnt_q,
    input logic             lvl_q,
    input logic             run_q
);

    // R2
    stop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (cnt_q == '0));

    // R3
    clr_on_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !mode_sel[1] && clr_sel && match_a_o) |=> (cnt_q == '0));

    // R4
    clr_on_p_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !mode_sel[1] && !clr_sel && (cmp_p != '0) && match_p_o)
        |=> (cnt_q == '0));

    // R4
    wrap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !mode_sel[1] && !clr_sel && (cmp_p == '0) && (&cnt_q))
        |=> (cnt_q == '0));

    // R5
    start_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b01 && run_en && !run_q) |=> (lvl_q == $past(lvl_ctl)));

    // R6
    drive_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b01 && run_en && run_q && match_a_o && out_act == 2'b10)
        |=> lvl_q);

    // R6
    drive_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b01 && run_en && run_q && match_a_o && out_act == 2'b01)
        |=> !lvl_q);

    // R7
    pwm_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b10 && run_en && (cnt_q < cmp_a))
        |=> (lvl_q == $past(lvl_ctl)));

    // R11
    flags_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> (!match_a_o && !match_p_o));

endmodule

bind ptmr_top ptmr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .mode_sel  (mode_sel),
    .out_act   (out_act),
    .lvl_ctl   (lvl_ctl),
    .clr_sel   (clr_sel),
    .cmp_a     (cmp_a),
    .cmp_p     (cmp_p),
    .match_a_o (match_a_o),
    .match_p_o (match_p_o),
    .cnt_q     (cnt_q),
    .lvl_q     (lvl_q),
    .run_q     (run_q)
);

// File: tb/tb_ptmr_top.sv
module tb_ptmr_top;

    localparam int W    = 10;
    localparam int HALF = 2500;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         run_en = 1'b0;
    logic [1:0]   mode_sel = 2'b00;
    logic [1:0]   out_act = 2'b00;
    logic         lvl_ctl = 1'b0;
    logic         pol_inv = 1'b0;
    logic         clr_sel = 1'b0;
    logic [W-1:0] cmp_a = '0;
    logic [W-1:0] cmp_p = '0;
    logic         pin_o, pin_n_o, match_a_o, match_p_o;

    always #(HALF) clk = ~clk;

    ptmr_top #(.CNT_W(W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .mode_sel  (mode_sel),
        .out_act   (out_act),
        .lvl_ctl   (lvl_ctl),
        .pol_inv   (pol_inv),
        .clr_sel   (clr_sel),
        .cmp_a     (cmp_a),
        .cmp_p     (cmp_p),
        .pin_o     (pin_o),
        .pin_n_o   (pin_n_o),
        .match_a_o (match_a_o),
        .match_p_o (match_p_o)
    );

    typedef struct {
        logic  pin;
        logic  ma;
        logic  mp;
        string tag;
    } exp_t;

    exp_t   sb_q[$];
    event   sample_ev;
    int     n_total = 0;
    int     n_fail  = 0;
    bit     done    = 1'b0;

    logic [W-1:0] m_cnt  = '0;
    logic         m_lvl  = 1'b0;
    logic         m_runq = 1'b0;

    // predict this cycle, hand it to the monitor, then step the model over the edge
    task automatic cyc(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            exp_t         e;
            logic [W-1:0] last;
            logic         per, ma, mp, wrap, nl;
            per  = mode_sel[1];
            last = (cmp_p == '0) ? '1 : cmp_p - W'(1);
            ma   = run_en && (m_cnt == cmp_a);
            mp   = run_en && (per ? (m_cnt == last) : (m_cnt == cmp_p));
            e.pin = (mode_sel == 2'b01 || mode_sel == 2'b10) ? (m_lvl ^ pol_inv) : 1'b0;
            e.ma  = ma;
            e.mp  = mp;
            e.tag = tag;
            sb_q.push_back(e);
            -> sample_ev;
            #100;
            if (per)          wrap = (m_cnt == last);
            else if (clr_sel) wrap = (m_cnt == cmp_a);
            else if (cmp_p == '0) wrap = (m_cnt == '1);
            else              wrap = (m_cnt == cmp_p);
            nl = 1'b0;
            case (mode_sel)
                2'b01: begin
                    nl = m_lvl;
                    if (run_en && !m_runq) nl = lvl_ctl;
                    else if (run_en && ma) begin
                        case (out_act)
                            2'b01:   nl = 1'b0;
                            2'b10:   nl = 1'b1;
                            2'b11:   nl = ~m_lvl;
                            default: nl = m_lvl;
                        endcase
                    end
                end
                2'b10: nl = (run_en && (m_cnt < cmp_a)) ? lvl_ctl : ~lvl_ctl;
                default: nl = 1'b0;
            endcase
            m_cnt  = !run_en ? '0 : (wrap ? '0 : m_cnt + W'(1));
            m_lvl  = nl;
            m_runq = run_en;
            @(negedge clk);
            #200;
        end
    endtask

    // monitor: compare the queued prediction with the ports in the same cycle
    always @(sample_ev) begin
        exp_t e;
        #50;
        if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            n_total++;
            if (pin_o !== e.pin || match_a_o !== e.ma || match_p_o !== e.mp) begin
                n_fail++;
                $display("FAIL %s: pin/ma/mp = %b%b%b expected %b%b%b at %0t",
                         e.tag, pin_o, match_a_o, match_p_o, e.pin, e.ma, e.mp, $time);
            end
            // R10 complementary pin
            n_total++;
            if (pin_n_o !== ~pin_o) begin
                n_fail++;
                $display("FAIL R10: pin_n=%b expected %b", pin_n_o, ~pin_o);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #200;
        cyc("R1", 3);

        // count mode, clear on A; pin inert (R9)
        mode_sel = 2'b00; clr_sel = 1'b1; cmp_a = 10'd5; cmp_p = 10'd20;
        lvl_ctl = 1'b1; pol_inv = 1'b1; run_en = 1'b1;
        cyc("R3", 20);
        cyc("R9", 5);
        run_en = 1'b0;
        cyc("R2", 3);

        // clear on P, then overflow wrap with P = 0
        clr_sel = 1'b0; cmp_p = 10'd7; run_en = 1'b1;
        cyc("R4", 20);
        run_en = 1'b0;
        cyc("R2", 2);
        cmp_p = '0; run_en = 1'b1;
        cyc("R4", 1030);
        run_en = 1'b0;
        cyc("R11", 2);

        // compare mode: drive high from initial low
        mode_sel = 2'b01; pol_inv = 1'b0; lvl_ctl = 1'b0; out_act = 2'b10;
        cmp_a = 10'd3; cmp_p = 10'd9; run_en = 1'b1;
        cyc("R6", 25);
        run_en = 1'b0;
        cyc("R5", 3);
        run_en = 1'b1;
        cyc("R5", 4);
        cyc("R6", 10);
        run_en = 1'b0;
        cyc("R2", 2);

        // drive low from initial high, with clear on A
        lvl_ctl = 1'b1; out_act = 2'b01; clr_sel = 1'b1; run_en = 1'b1;
        cyc("R6", 25);
        run_en = 1'b0;
        cyc("R5", 2);
        out_act = 2'b11; clr_sel = 1'b0; run_en = 1'b1;
        cyc("R6", 40);
        out_act = 2'b00;
        cyc("R6", 20);
        run_en = 1'b0;
        cyc("R5", 2);
        out_act = 2'b10; run_en = 1'b1;
        cyc("R6", 25);
        pol_inv = 1'b1;
        cyc("R8", 15);
        run_en = 1'b0;
        cyc("R2", 2);

        // PWM, clear select ignored
        mode_sel = 2'b10; lvl_ctl = 1'b1; pol_inv = 1'b0; clr_sel = 1'b1;
        cmp_a = 10'd3; cmp_p = 10'd8; run_en = 1'b1;
        cyc("R7", 30);
        pol_inv = 1'b1;
        cyc("R8", 10);
        run_en = 1'b0;
        cyc("R7", 2);
        lvl_ctl = 1'b0; pol_inv = 1'b0; cmp_p = '0; cmp_a = 10'd512; run_en = 1'b1;
        cyc("R7", 2100);
        run_en = 1'b0;
        cyc("R2", 2);

        // auxiliary mode: P period, pin inert
        mode_sel = 2'b11; clr_sel = 1'b1; lvl_ctl = 1'b1; pol_inv = 1'b1;
        cmp_a = 10'd2; cmp_p = 10'd6; run_en = 1'b1;
        cyc("R9", 20);
        cyc("R11", 5);

        #1000;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule